// File: doc/BRIEF.md
# Integer Issue Pipe Slotting Unit

This block sits between instruction decode and the integer execution pipes of a four-wide core. In every cycle it takes a group of up to four decoded integer-side instructions, held oldest first, each tagged with a 4-bit operation class. It places each one on one of four asymmetric pipes. There are two upper pipes, U0 and U1, and two lower pipes, L0 and L1. Cluster 0 holds U0 and L0, and cluster 1 holds U1 and L1. Each class may use only a fixed subset of the pipes. Older instructions choose first, and each takes the lowest-numbered legal pipe that is still free.

If a valid instruction finds no legal free pipe, it stalls, and every younger instruction in the group stalls with it. The stall output gives the index of the instruction that stalled first, so the front end can present it again in the next group. For each instruction that issues, the block reports the pipe it received and two ready cycles. The first is when a consumer on the same cluster can use the result. The second is when a consumer on the other cluster can use it. A conditional move holds its pipe for a second cycle, and a "multi" instruction occupies the whole machine.

All results are registered, so they appear one clock after the group is presented.

Top module: `int_issue_slotter`

## Requirements
- R1: Pipe codes are 0 = U0, 1 = U1, 2 = L0, 3 = L1. No two instructions issued in the same cycle get the same pipe. Each issued instruction gets the lowest-numbered legal pipe not already taken by an older instruction or held by a reservation.
- R2: Class 0 (add, logic, compare) may use any pipe and has a latency of 1.
- R3: Class 1 (shift) and class 2 (integer branch) may use only U0 or U1, with a latency of 1.
- R4: Class 3 (load) and class 4 (store) may use only L0 or L1. A load reports a latency of LOAD_LAT, which is 1 by default. A store reports a latency of 1. Class 10 (integer-to-FP transfer) may use only L0 or L1, with a latency of 3.
- R5: Class 5 (memory barrier) may use only L1. Class 6 (subroutine call) may use only L0. Both have a latency of 1.
- R6: Class 7 (motion video) may use only U0, with a latency of 3. Class 8 (multiply) may use only U1, with a latency of 7.
- R7: Class 9 (conditional move) may use any pipe and has a latency of 2. Its pipe cannot be given to any instruction in the following cycle.
- R8: Class 11 (multi) issues only when all four pipes are free. It then takes all of them, reports pipe 0 and a latency of 1, and nothing younger issues in that cycle.
- R9: Slots are taken in program order, slot 0 first, and slots with in_vld low are skipped. The first valid instruction that cannot be placed raises stall with its index on stall_idx, and no younger slot issues. Class codes 12 to 15 can never be placed. A group that places every valid instruction leaves stall low.
- R10: The issue cycle is the count of clock cycles since reset, starting at 0 in the first cycle after reset is released. For an issued instruction, rdy_near equals the issue cycle plus its latency, and rdy_far equals rdy_near plus one.
- R11: All outputs are registered and appear one clock after the group is presented. Reset clears the outputs, any conditional-move reservation, and the cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | NSLOT | Valid flag for each slot; slot 0 is the oldest |
| in_cls | input | NSLOT*4 | Operation class of each slot, 4 bits per slot |
| iss_vld | output | NSLOT | Slot issued in the registered group |
| iss_pipe | output | NSLOT*2 | Pipe code given to each slot |
| rdy_near | output | NSLOT*CYC_W | Cycle at which the result is ready for a consumer on the same cluster |
| rdy_far | output | NSLOT*CYC_W | Cycle at which the result is ready for a consumer on the other cluster |
| stall | output | 1 | A valid slot could not be placed |
| stall_idx | output | SIDX_W | Index of the first slot that stalled |

## Verification
Every result for a group is due exactly one clock after the group is presented. The bench drives each group on a falling edge and samples on the next falling edge, which lies after the single rising edge that registers the result. The ready cycles are predicted from a count of rising edges since reset: the issue cycle is that count minus one at the sampling point. The effect of a conditional-move reservation appears in the group presented immediately after the one that issued the move, so the table applies those groups in consecutive cycles.

// File: rtl/islot_pkg.sv
package islot_pkg;

  localparam int NPIPE  = 4;
  localparam int PIPE_W = 2;
  localparam int CLS_W  = 4;
  localparam int LAT_W  = 4;

  typedef enum logic [CLS_W-1:0] {
    CL_ARITH   = 4'd0,
    CL_SHIFT   = 4'd1,
    CL_BRANCH  = 4'd2,
    CL_LOAD    = 4'd3,
    CL_STORE   = 4'd4,
    CL_BARRIER = 4'd5,
    CL_CALL    = 4'd6,
    CL_VIDEO   = 4'd7,
    CL_MUL     = 4'd8,
    CL_CMOV    = 4'd9,
    CL_TOFP    = 4'd10,
    CL_MULTI   = 4'd11
  } op_cls_e;

  // pipe mask bits: 0 = U0, 1 = U1, 2 = L0, 3 = L1
  localparam logic [NPIPE-1:0] M_ANY   = 4'b1111;
  localparam logic [NPIPE-1:0] M_UPPER = 4'b0011;
  localparam logic [NPIPE-1:0] M_LOWER = 4'b1100;

  function automatic logic [NPIPE-1:0] legal_mask(input logic [CLS_W-1:0] c);
    logic [NPIPE-1:0] m;
    case (c)
      CL_ARITH, CL_CMOV, CL_MULTI: m = M_ANY;
      CL_SHIFT, CL_BRANCH:         m = M_UPPER;
      CL_LOAD, CL_STORE, CL_TOFP:  m = M_LOWER;
      CL_BARRIER:                  m = 4'b1000;
      CL_CALL:                     m = 4'b0100;
      CL_VIDEO:                    m = 4'b0001;
      CL_MUL:                      m = 4'b0010;
      default:                     m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [LAT_W-1:0] base_lat(input logic [CLS_W-1:0] c,
                                                input logic [LAT_W-1:0] ld_lat);
    logic [LAT_W-1:0] l;
    case (c)
      CL_LOAD:           l = ld_lat;
      CL_VIDEO, CL_TOFP: l = 4'd3;
      CL_MUL:            l = 4'd7;
      CL_CMOV:           l = 4'd2;
      default:           l = 4'd1;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/islot_pick.sv
module islot_pick
  import islot_pkg::*;
(
  input  logic                  vld,
  input  logic [CLS_W-1:0]      cls,
  input  logic                  blk_in,
  input  logic [NPIPE-1:0]      free_in,
  output logic                  grant,
  output logic [PIPE_W-1:0]     pipe,
  output logic [NPIPE-1:0]      take,
  output logic                  stall_here,
  output logic                  blk_out,
  output logic [NPIPE-1:0]      free_out
);

  logic [NPIPE-1:0] cand;
  logic             fits;
  logic             whole;

  always_comb begin
    cand  = legal_mask(cls) & free_in;
    whole = (cls == CL_MULTI);
    fits  = whole ? (&free_in) : (|cand);
    pipe  = '0;
    take  = '0;
    if (!whole) begin
      for (int p = NPIPE-1; p >= 0; p--) begin
        if (cand[p]) begin
          pipe = PIPE_W'(p);
        end
      end
      if (fits) take[pipe] = 1'b1;
    end else if (fits) begin
      take = '1;
    end
    grant      = vld && !blk_in && fits;
    stall_here = vld && !blk_in && !fits;
    blk_out    = blk_in || stall_here;
    free_out   = grant ? (free_in & ~take) : free_in;
  end

endmodule

// File: rtl/islot_resv.sv
module islot_resv
  import islot_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NPIPE-1:0] hold_next,
  output logic [NPIPE-1:0] busy
);

  always_ff @(posedge clk) begin
    if (rst) busy <= '0;
    else     busy <= hold_next;
  end

endmodule

// File: rtl/islot_cyc_ctr.sv
module islot_cyc_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cyc
);

  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else     cyc <= cyc + 1'b1;
  end

endmodule

// File: rtl/int_issue_slotter.sv
module int_issue_slotter
  import islot_pkg::*;
#(
  parameter int NSLOT    = 4,
  parameter int CYC_W    = 16,
  parameter int LOAD_LAT = 1,
  parameter int XCL_PEN  = 1,
  localparam int SIDX_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSLOT-1:0]        in_vld,
  input  logic [NSLOT*CLS_W-1:0]  in_cls,
  output logic [NSLOT-1:0]        iss_vld,
  output logic [NSLOT*PIPE_W-1:0] iss_pipe,
  output logic [NSLOT*CYC_W-1:0]  rdy_near,
  output logic [NSLOT*CYC_W-1:0]  rdy_far,
  output logic                    stall,
  output logic [SIDX_W-1:0]       stall_idx
);

  logic [CYC_W-1:0]  cyc;
  logic [NPIPE-1:0]  busy;
  logic [NPIPE-1:0]  hold_next;
  logic [NPIPE-1:0]  free_c [NSLOT+1];
  logic              blk_c  [NSLOT+1];
  logic [NSLOT-1:0]  grant_c;
  logic [NSLOT-1:0]  stall_c;
  logic [NPIPE-1:0]  take_c [NSLOT];
  logic [PIPE_W-1:0] pipe_c [NSLOT];
  logic [CYC_W-1:0]  near_c [NSLOT];
  logic [NSLOT-1:0]  is_cmov;

  islot_cyc_ctr #(.W(CYC_W)) u_ctr (
    .clk (clk),
    .rst (rst),
    .cyc (cyc)
  );

  islot_resv u_resv (
    .clk       (clk),
    .rst       (rst),
    .hold_next (hold_next),
    .busy      (busy)
  );

  assign free_c[0] = ~busy;
  assign blk_c[0]  = 1'b0;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [CLS_W-1:0] cls_s;
    assign cls_s = in_cls[s*CLS_W +: CLS_W];

    islot_pick u_pick (
      .vld        (in_vld[s]),
      .cls        (cls_s),
      .blk_in     (blk_c[s]),
      .free_in    (free_c[s]),
      .grant      (grant_c[s]),
      .pipe       (pipe_c[s]),
      .take       (take_c[s]),
      .stall_here (stall_c[s]),
      .blk_out    (blk_c[s+1]),
      .free_out   (free_c[s+1])
    );

    assign is_cmov[s] = grant_c[s] && (cls_s == CL_CMOV);
    assign near_c[s]  = cyc + CYC_W'(base_lat(cls_s, LAT_W'(LOAD_LAT)));
  end

  always_comb begin
    hold_next = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (is_cmov[s]) hold_next = hold_next | take_c[s];
    end
  end

  logic [SIDX_W-1:0] sidx_c;
  always_comb begin
    sidx_c = '0;
    for (int s = NSLOT-1; s >= 0; s--) begin
      if (stall_c[s]) sidx_c = SIDX_W'(s);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_vld   <= '0;
      iss_pipe  <= '0;
      rdy_near  <= '0;
      rdy_far   <= '0;
      stall     <= 1'b0;
      stall_idx <= '0;
    end else begin
      iss_vld   <= grant_c;
      stall     <= |stall_c;
      stall_idx <= sidx_c;
      for (int s = 0; s < NSLOT; s++) begin
        iss_pipe[s*PIPE_W +: PIPE_W] <= grant_c[s] ? pipe_c[s] : '0;
        rdy_near[s*CYC_W +: CYC_W]   <= grant_c[s] ? near_c[s] : '0;
        rdy_far[s*CYC_W +: CYC_W]    <= grant_c[s] ? near_c[s] + CYC_W'(XCL_PEN) : '0;
      end
    end
  end

endmodule

// File: rtl/int_issue_slotter_chk.sv
module int_issue_slotter_chk
  import islot_pkg::*;
#(
  parameter int NSLOT    = 4,
  parameter int CYC_W    = 16,
  parameter int LOAD_LAT = 1,
  parameter int XCL_PEN  = 1,
  localparam int SIDX_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NSLOT-1:0]        in_vld,
  input logic [NSLOT*CLS_W-1:0]  in_cls,
  input logic [NSLOT-1:0]        iss_vld,
  input logic [NSLOT*PIPE_W-1:0] iss_pipe,
  input logic [NSLOT*CYC_W-1:0]  rdy_near,
  input logic [NSLOT*CYC_W-1:0]  rdy_far,
  input logic                    stall,
  input logic [SIDX_W-1:0]       stall_idx
);

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (iss_vld == '0) && !stall);

  assert_stall_blocks_younger_R9: assert property (@(posedge clk) disable iff (rst)
    stall |-> ((iss_vld >> stall_idx) == '0));

  for (genvar s = 0; s < NSLOT; s++) begin : g_a
    logic [PIPE_W-1:0] ps;
    logic [CYC_W-1:0]  ns, fs;
    assign ps = iss_pipe[s*PIPE_W +: PIPE_W];
    assign ns = rdy_near[s*CYC_W +: CYC_W];
    assign fs = rdy_far[s*CYC_W +: CYC_W];

    assert_far_one_later_R10: assert property (@(posedge clk) disable iff (rst)
      iss_vld[s] |-> (fs == ns + CYC_W'(XCL_PEN)));

    assert_upper_only_R3: assert property (@(posedge clk) disable iff (rst)
      (iss_vld[s] && ($past(in_cls[s*CLS_W +: CLS_W]) == CL_SHIFT ||
                      $past(in_cls[s*CLS_W +: CLS_W]) == CL_BRANCH)) |-> (ps[1] == 1'b0));

    assert_mul_on_u1_R6: assert property (@(posedge clk) disable iff (rst)
      (iss_vld[s] && $past(in_cls[s*CLS_W +: CLS_W]) == CL_MUL) |-> (ps == 2'd1));

    assert_multi_alone_R8: assert property (@(posedge clk) disable iff (rst)
      (iss_vld[s] && $past(in_cls[s*CLS_W +: CLS_W]) == CL_MULTI) |-> ($countones(iss_vld) == 1));

    for (genvar t = 0; t < NSLOT; t++) begin : g_b
      if (t > s) begin : g_pair
        assert_distinct_pipes_R1: assert property (@(posedge clk) disable iff (rst)
          (iss_vld[s] && iss_vld[t]) |-> (ps != iss_pipe[t*PIPE_W +: PIPE_W]));
      end
      assert_cmov_holds_pipe_R7: assert property (@(posedge clk) disable iff (rst)
        (iss_vld[s] && $past(in_cls[s*CLS_W +: CLS_W]) == CL_CMOV) |=>
          !(iss_vld[t] && iss_pipe[t*PIPE_W +: PIPE_W] == $past(ps)));
    end
  end

endmodule

bind int_issue_slotter int_issue_slotter_chk #(
  .NSLOT(NSLOT), .CYC_W(CYC_W), .LOAD_LAT(LOAD_LAT), .XCL_PEN(XCL_PEN)
) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_cls(in_cls),
  .iss_vld(iss_vld), .iss_pipe(iss_pipe), .rdy_near(rdy_near),
  .rdy_far(rdy_far), .stall(stall), .stall_idx(stall_idx)
);

// File: tb/int_issue_slotter_tb.sv
`timescale 1ns/1ps
module int_issue_slotter_tb;

  localparam int CW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  in_vld = '0;
  logic [15:0] in_cls = '0;
  logic [3:0]  iss_vld;
  logic [7:0]  iss_pipe;
  logic [63:0] rdy_near, rdy_far;
  logic        stall;
  logic [1:0]  stall_idx;

  int checks = 0;
  int errors = 0;
  logic [CW-1:0] tb_cyc = '0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) tb_cyc <= '0;
    else     tb_cyc <= tb_cyc + 1'b1;
  end

  int_issue_slotter u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_cls(in_cls),
    .iss_vld(iss_vld), .iss_pipe(iss_pipe), .rdy_near(rdy_near),
    .rdy_far(rdy_far), .stall(stall), .stall_idx(stall_idx)
  );

  typedef struct packed {
    logic [3:0]  v;
    logic [15:0] cls;
    logic [3:0]  iss;
    logic [7:0]  pipe;
    logic [15:0] lat;
    logic        st;
    logic [1:0]  sidx;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{4'hF, 16'h0000, 4'hF, 8'hE4, 16'h1111, 1'b0, 2'd0},
    '{4'hF, 16'h3111, 4'h3, 8'h04, 16'h0011, 1'b1, 2'd2},
    '{4'hF, 16'h6578, 4'hF, 8'hB1, 16'h1137, 1'b0, 2'd0},
    '{4'hF, 16'h0B09, 4'h3, 8'h04, 16'h0012, 1'b1, 2'd2},
    '{4'hF, 16'h0007, 4'h0, 8'h00, 16'h0000, 1'b1, 2'd0},
    '{4'hF, 16'h4AA7, 4'h7, 8'h38, 16'h0333, 1'b1, 2'd3},
    '{4'h3, 16'h000B, 4'h1, 8'h00, 16'h0001, 1'b1, 2'd1},
    '{4'hA, 16'h3030, 4'hA, 8'hC8, 16'h1010, 1'b0, 2'd0},
    '{4'hF, 16'h9999, 4'hF, 8'hE4, 16'h2222, 1'b0, 2'd0},
    '{4'hF, 16'h0000, 4'h0, 8'h00, 16'h0000, 1'b1, 2'd0},
    '{4'hF, 16'h0000, 4'hF, 8'hE4, 16'h1111, 1'b0, 2'd0},
    '{4'hF, 16'h6532, 4'h7, 8'h38, 16'h0111, 1'b1, 2'd3},
    '{4'h1, 16'h000F, 4'h0, 8'h00, 16'h0000, 1'b1, 2'd0},
    '{4'h0, 16'h0000, 4'h0, 8'h00, 16'h0000, 1'b0, 2'd0}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 10:         return "R2";
      1:             return "R3";
      2:             return "R6";
      3, 6:          return "R8";
      4, 8, 9:       return "R7";
      5:             return "R4";
      11:            return "R5";
      default:       return "R9";
    endcase
  endfunction

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v, input logic [15:0] c);
    in_vld = v;
    in_cls = c;
  endtask

  // sampled one falling edge after the group was driven
  task automatic check_group(input string req, input vec_t e);
    logic [CW-1:0] base;
    base = tb_cyc - 1'b1;
    check_eq(req, "issue mask", 32'(iss_vld), 32'(e.iss));
    check_eq("R9", "stall", 32'(stall), 32'(e.st));
    if (e.st) check_eq("R9", "stall index", 32'(stall_idx), 32'(e.sidx));
    for (int s = 0; s < 4; s++) begin
      if (e.iss[s]) begin
        check_eq({"R1 ", req}, $sformatf("pipe slot %0d", s),
                 32'(iss_pipe[s*2 +: 2]), 32'(e.pipe[s*2 +: 2]));
        check_eq("R10", $sformatf("near slot %0d", s),
                 32'(rdy_near[s*CW +: CW]), 32'(base + CW'(e.lat[s*4 +: 4])));
        check_eq("R10", $sformatf("far slot %0d", s),
                 32'(rdy_far[s*CW +: CW]), 32'(base + CW'(e.lat[s*4 +: 4]) + 1'b1));
      end
    end
  endtask

  bit done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t allarith;
    allarith = TBL[0];
    repeat (3) @(negedge clk);
    check_eq("R11", "reset issue mask", 32'(iss_vld), 32'h0);
    check_eq("R11", "reset stall", 32'(stall), 32'h0);
    check_eq("R11", "reset near", rdy_near[31:0], 32'h0);

    rst = 1'b0;
    // first group after reset: issue cycle 0
    drive(4'h1, 16'h0008);
    @(negedge clk);
    check_eq("R10", "near at cycle 0", 32'(rdy_near[15:0]), 32'd7);
    check_eq("R10", "far at cycle 0", 32'(rdy_far[15:0]), 32'd8);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].v, TBL[i].cls);
      @(negedge clk);
      check_group(tag_of(i), TBL[i]);
    end

    // reset drops a pending cmov reservation
    drive(4'hF, 16'h9999);
    @(negedge clk);
    check_group("R7", TBL[8]);
    rst = 1'b1;
    drive(4'h0, 16'h0000);
    @(negedge clk);
    check_eq("R11", "outputs clear in reset", 32'(iss_vld), 32'h0);
    rst = 1'b0;
    drive(allarith.v, allarith.cls);
    @(negedge clk);
    check_group("R11", allarith);

    // loads and stores fill both lower pipes, younger shift still issues
    drive(4'hF, 16'h1043);
    @(negedge clk);
    check_eq("R4", "issue mask", 32'(iss_vld), 32'hF);
    check_eq("R4", "load pipe", 32'(iss_pipe[1:0]), 32'd2);
    check_eq("R4", "store pipe", 32'(iss_pipe[3:2]), 32'd3);
    check_eq("R1", "arith pipe", 32'(iss_pipe[5:4]), 32'd0);
    check_eq("R3", "shift pipe", 32'(iss_pipe[7:6]), 32'd1);

    drive(4'h0, 16'h0000);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule